// File: doc/BRIEF.md
# Reset Controller with Cause Flags

This block gathers every reset request in the chip into a single chip reset. The requests are power-on, the external reset pin, watchdog time-out, brown-out, a software reset command, and the two stack faults (full and underflow). Any request sets a latch that drives `chip_rst`. The latch is held until a power-up timer has counted 2048 ticks, so the rest of the chip leaves reset only after a fixed delay following the last request.

The block also records the cause of each reset in sticky flag bits. Each flag is active low: a 0 means that its event has occurred. Power-on loads a fixed pattern, and every other cause clears only its own bit. Software reads the whole flag register and decodes the cause from the combination of bits. Writing a 1 to a flag re-arms it. A 0 written to a flag does nothing, so software can never fake an event.

Bit 7 of the same register is an interrupt-priority enable. Software can read and write it, and it has no effect on reset. The tick that drives the timer comes from a clock divider whose ratio is set by the `TICK_DIV` parameter. The default ratio gives about 32 µs per tick at 100 MHz.

Top module: `rstctl_top`

## Requirements
- R1: When `por` is high, `chip_rst` is set to 1 and `reg_rdata` becomes 8'h7C: flag bits [0] brown-out and [1] power-on are 0, flag bits [6:2] are 1, and the priority bit [7] is 0.
- R2: After the last clock edge that samples a request, `chip_rst` stays 1 for exactly 2048×`TICK_DIV` clock cycles and then falls to 0.
- R3: A request that arrives while the timer is running restarts the count, so the full 2048×`TICK_DIV` delay is measured from that newer request.
- R4: `ext_rst` with `pm_mode` low asserts `chip_rst` and leaves every flag bit unchanged.
- R5: `ext_rst` with `pm_mode` high asserts `chip_rst` and clears flag bit [2].
- R6: `wdt_timeout` asserts `chip_rst` and clears flag bit [3].
- R7: `bor_det` with `bor_en` high asserts `chip_rst` and clears flag bit [0]. With `bor_en` low, `bor_det` has no effect on `chip_rst` or on the flags.
- R8: `sw_reset` asserts `chip_rst` and clears flag bit [4].
- R9: `stk_full` asserts `chip_rst` and clears flag bit [5]. `stk_under` asserts `chip_rst` and clears flag bit [6].
- R10: A register write sets to 1 every flag bit whose `reg_wdata` bit is 1. Flag bits whose `reg_wdata` bit is 0 keep their value.
- R11: When a hardware event and a software write of 1 hit the same flag bit in the same cycle, the bit becomes 0.
- R12: A register write loads `reg_wdata[7]` into priority bit [7]. This bit never affects `chip_rst`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on request; synchronous, active high; also initialises the block |
| ext_rst | input | 1 | External pin reset request, active high |
| pm_mode | input | 1 | High while the chip is in a power-managed mode |
| wdt_timeout | input | 1 | Watchdog time-out request |
| bor_det | input | 1 | Brown-out detected |
| bor_en | input | 1 | Regulator enable; gates brown-out |
| sw_reset | input | 1 | Software reset command |
| stk_full | input | 1 | Stack full fault |
| stk_under | input | 1 | Stack underflow fault |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data: {priority, flags[6:0]} |
| chip_rst | output | 1 | Chip reset output |

## Verification
A request and its flag update both take effect on the same rising edge. The new values of `chip_rst` and `reg_rdata` are therefore visible one edge after the request is driven, and a software write takes effect on the edge that samples it. The bench changes inputs and samples outputs only on falling edges, and it reads the flags at the first falling edge after the request edge. Release is checked by counting the falling edges on which `chip_rst` is still high and comparing that count with 2048×`TICK_DIV`. The restart case takes this count from the second request.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;

    localparam int FLAG_W = 7;

    // Active-low sticky cause flags; bit order is the software-visible layout.
    typedef struct packed {
        logic n_sunf;   // [6] stack underflow
        logic n_sfull;  // [5] stack full
        logic n_swr;    // [4] software reset command
        logic n_wdt;    // [3] watchdog time-out
        logic n_pmx;    // [2] external reset in power-managed mode
        logic n_por;    // [1] power-on
        logic n_bor;    // [0] brown-out
    } flags_t;

    // Active-high event strobes in the same bit order as flags_t.
    typedef struct packed {
        logic sunf;
        logic sfull;
        logic swr;
        logic wdt;
        logic pmx;
        logic por;
        logic bor;
    } events_t;

    localparam flags_t POR_FLAGS = 7'b111_1100;

    function automatic logic any_event(input events_t e, input logic ext_run);
        return (|e) | ext_run;
    endfunction

endpackage

// File: rtl/rstctl_merge.sv
module rstctl_merge
    import rstctl_pkg::*;
(
    input  logic    por,
    input  logic    ext_rst,
    input  logic    pm_mode,
    input  logic    wdt_timeout,
    input  logic    bor_det,
    input  logic    bor_en,
    input  logic    sw_reset,
    input  logic    stk_full,
    input  logic    stk_under,
    output events_t ev,
    output logic    req
);
    logic ext_run;

    always_comb begin
        ev       = '0;
        ev.por   = por;
        ev.bor   = bor_det & bor_en;
        ev.pmx   = ext_rst & pm_mode;
        ev.wdt   = wdt_timeout;
        ev.swr   = sw_reset;
        ev.sfull = stk_full;
        ev.sunf  = stk_under;
        ext_run  = ext_rst & ~pm_mode;
        req      = any_event(ev, ext_run);
    end

endmodule

// File: rtl/rstctl_pwrt.sv
module rstctl_pwrt #(
    parameter int TICK_DIV  = 3200,
    parameter int PWRT_BITS = 11
) (
    input  logic clk,
    input  logic por,
    input  logic req,
    output logic chip_rst
);
    localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic                 tick;
    logic [PWRT_BITS-1:0] cnt;

    generate
        if (TICK_DIV > 1) begin : g_div
            localparam logic [DW-1:0] DIV_LAST = DW'(TICK_DIV - 1);
            logic [DW-1:0] div;
            always_ff @(posedge clk) begin
                if (req || !chip_rst)  div <= '0;
                else if (div == DIV_LAST) div <= '0;
                else                   div <= div + 1'b1;
            end
            assign tick = chip_rst && (div == DIV_LAST);
        end else begin : g_nodiv
            assign tick = chip_rst;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (req) begin
            chip_rst <= 1'b1;
            cnt      <= '0;
        end else if (tick) begin
            if (cnt == '1) chip_rst <= 1'b0;
            cnt <= cnt + 1'b1;
        end
    end

    // R2: release never happens while a request is present
    a_r2_release_idle: assert property (@(posedge clk) disable iff (por)
        $fell(chip_rst) |-> !$past(req));

    // R2: reset held until the counter has reached its last value
    a_r2_hold: assert property (@(posedge clk) disable iff (por)
        (chip_rst && !req && cnt != '1) |=> chip_rst);

    // R3: every request restarts the count and asserts reset
    a_r3_restart: assert property (@(posedge clk) disable iff (por)
        req |=> (chip_rst && cnt == '0));

endmodule

// File: rtl/rstctl_flags.sv
module rstctl_flags
    import rstctl_pkg::*;
(
    input  logic       clk,
    input  logic       por,
    input  events_t    ev,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output flags_t     flags,
    output logic       prio
);
    logic [FLAG_W-1:0] ev_v;
    logic [FLAG_W-1:0] fl_v;

    assign ev_v = ev;
    assign fl_v = flags;

    always_ff @(posedge clk) begin
        if (por) begin
            flags <= POR_FLAGS;
            prio  <= 1'b0;
        end else begin
            for (int i = 0; i < FLAG_W; i++) begin
                if (ev_v[i])                    flags[i] <= 1'b0;
                else if (reg_wr && reg_wdata[i]) flags[i] <= 1'b1;
            end
            if (reg_wr) prio <= reg_wdata[7];
        end
    end

    // R11: a hardware event always lands, even against a write of 1
    a_r11_hw_wins: assert property (@(posedge clk) disable iff (por)
        (|ev_v) |=> ((fl_v & $past(ev_v)) == '0));

    // R10: software can never drive a flag to the event-occurred value
    a_r10_no_sw_set: assert property (@(posedge clk) disable iff (por)
        reg_wr |=> ((~fl_v & $past(fl_v) & ~$past(ev_v)) == '0));

    // R12: priority bit follows the written value
    a_r12_prio_wr: assert property (@(posedge clk) disable iff (por)
        reg_wr |=> (prio == $past(reg_wdata[7])));

endmodule

// File: rtl/rstctl_top.sv
module rstctl_top
    import rstctl_pkg::*;
#(
    parameter int TICK_DIV  = 3200,
    parameter int PWRT_BITS = 11
) (
    input  logic       clk,
    input  logic       por,
    input  logic       ext_rst,
    input  logic       pm_mode,
    input  logic       wdt_timeout,
    input  logic       bor_det,
    input  logic       bor_en,
    input  logic       sw_reset,
    input  logic       stk_full,
    input  logic       stk_under,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       chip_rst
);
    events_t ev;
    logic    req;
    flags_t  flags;
    logic    prio;

    rstctl_merge u_merge (
        .por         (por),
        .ext_rst     (ext_rst),
        .pm_mode     (pm_mode),
        .wdt_timeout (wdt_timeout),
        .bor_det     (bor_det),
        .bor_en      (bor_en),
        .sw_reset    (sw_reset),
        .stk_full    (stk_full),
        .stk_under   (stk_under),
        .ev          (ev),
        .req         (req)
    );

    rstctl_pwrt #(
        .TICK_DIV  (TICK_DIV),
        .PWRT_BITS (PWRT_BITS)
    ) u_pwrt (
        .clk      (clk),
        .por      (por),
        .req      (req),
        .chip_rst (chip_rst)
    );

    rstctl_flags u_flags (
        .clk       (clk),
        .por       (por),
        .ev        (ev),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .flags     (flags),
        .prio      (prio)
    );

    assign reg_rdata = {prio, flags};

    // R7: brown-out flag only drops when the regulator enable was high
    a_r7_bor_gated: assert property (@(posedge clk) disable iff (por)
        $fell(flags.n_bor) |-> $past(bor_en && bor_det));

    // R4: external reset in normal run records nothing
    a_r4_ext_silent: assert property (@(posedge clk) disable iff (por)
        (ext_rst && !pm_mode && !reg_wr && !wdt_timeout && !bor_det && !sw_reset
         && !stk_full && !stk_under) |=> $stable(flags));

    // R12: writing the priority bit alone does not start a reset
    a_r12_no_reset: assert property (@(posedge clk) disable iff (por)
        (!chip_rst && !req) |=> !chip_rst);

endmodule

// File: tb/sim_rstctl_top.sv
module sim_rstctl_top;
    localparam int TD = 2;
    localparam int NREL = 2048 * TD;

    logic       clk = 1'b0;
    logic       por, ext_rst, pm_mode, wdt_timeout, bor_det, bor_en;
    logic       sw_reset, stk_full, stk_under, reg_wr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       chip_rst;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rstctl_top #(.TICK_DIV(TD), .PWRT_BITS(11)) u0 (
        .clk(clk), .por(por), .ext_rst(ext_rst), .pm_mode(pm_mode),
        .wdt_timeout(wdt_timeout), .bor_det(bor_det), .bor_en(bor_en),
        .sw_reset(sw_reset), .stk_full(stk_full), .stk_under(stk_under),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .chip_rst(chip_rst)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Counts falling edges with chip_rst high, starting at the current one.
    task automatic measure(input string req);
        int n = 0;
        while (chip_rst && n < NREL + 100) begin
            n++;
            @(negedge clk);
        end
        check(n == NREL, req, n, NREL);
    endtask

    task automatic wr(input logic [7:0] d);
        reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 8'h00;
    endtask

    task automatic rearm();
        wr(8'h7F);
    endtask

    task automatic t_power_on();
        por = 1'b1;
        repeat (3) @(negedge clk);
        check(chip_rst == 1'b1, "R1 chip_rst", chip_rst, 1);
        check(reg_rdata == 8'h7C, "R1 flags", reg_rdata, 8'h7C);
        por = 1'b0;
        measure("R2 por release");
    endtask

    task automatic t_ext_run();
        rearm();
        ext_rst = 1'b1; pm_mode = 1'b0;
        @(negedge clk);
        ext_rst = 1'b0;
        check(chip_rst == 1'b1, "R4 chip_rst", chip_rst, 1);
        check(reg_rdata == 8'h7F, "R4 flags unchanged", reg_rdata, 8'h7F);
        measure("R2 ext release");
    endtask

    task automatic t_ext_pm();
        rearm();
        ext_rst = 1'b1; pm_mode = 1'b1;
        @(negedge clk);
        ext_rst = 1'b0; pm_mode = 1'b0;
        check(chip_rst == 1'b1, "R5 chip_rst", chip_rst, 1);
        check(reg_rdata == 8'h7B, "R5 flags", reg_rdata, 8'h7B);
        measure("R2 pm release");
    endtask

    task automatic t_wdt();
        rearm();
        wdt_timeout = 1'b1;
        @(negedge clk);
        wdt_timeout = 1'b0;
        check(chip_rst == 1'b1, "R6 chip_rst", chip_rst, 1);
        check(reg_rdata == 8'h77, "R6 flags", reg_rdata, 8'h77);
        measure("R2 wdt release");
    endtask

    task automatic t_bor();
        rearm();
        bor_en = 1'b0; bor_det = 1'b1;
        @(negedge clk);
        bor_det = 1'b0;
        check(chip_rst == 1'b0, "R7 gated chip_rst", chip_rst, 0);
        check(reg_rdata == 8'h7F, "R7 gated flags", reg_rdata, 8'h7F);
        bor_en = 1'b1; bor_det = 1'b1;
        @(negedge clk);
        bor_det = 1'b0;
        check(chip_rst == 1'b1, "R7 chip_rst", chip_rst, 1);
        check(reg_rdata == 8'h7E, "R7 flags", reg_rdata, 8'h7E);
        measure("R2 bor release");
    endtask

    task automatic t_swr();
        rearm();
        sw_reset = 1'b1;
        @(negedge clk);
        sw_reset = 1'b0;
        check(chip_rst == 1'b1, "R8 chip_rst", chip_rst, 1);
        check(reg_rdata == 8'h6F, "R8 flags", reg_rdata, 8'h6F);
        measure("R2 swr release");
    endtask

    task automatic t_stack();
        rearm();
        stk_full = 1'b1;
        @(negedge clk);
        stk_full = 1'b0;
        check(reg_rdata == 8'h5F, "R9 full flag", reg_rdata, 8'h5F);
        measure("R2 full release");
        rearm();
        stk_under = 1'b1;
        @(negedge clk);
        stk_under = 1'b0;
        check(chip_rst == 1'b1, "R9 chip_rst", chip_rst, 1);
        check(reg_rdata == 8'h3F, "R9 underflow flag", reg_rdata, 8'h3F);
        measure("R2 under release");
    endtask

    task automatic t_restart();
        rearm();
        sw_reset = 1'b1;
        @(negedge clk);
        sw_reset = 1'b0;
        repeat (1000) @(negedge clk);
        check(chip_rst == 1'b1, "R3 still held", chip_rst, 1);
        wdt_timeout = 1'b1;
        @(negedge clk);
        wdt_timeout = 1'b0;
        measure("R3 restart length");
    endtask

    task automatic t_sw_write();
        rearm();
        wdt_timeout = 1'b1; sw_reset = 1'b1;
        @(negedge clk);
        wdt_timeout = 1'b0; sw_reset = 1'b0;
        measure("R2 pair release");
        check(reg_rdata == 8'h67, "R10 both recorded", reg_rdata, 8'h67);
        wr(8'h00);
        check(reg_rdata == 8'h67, "R10 zero write no effect", reg_rdata, 8'h67);
        wr(8'h08);
        check(reg_rdata == 8'h6F, "R10 rearm one bit", reg_rdata, 8'h6F);
        check(chip_rst == 1'b0, "R10 no reset", chip_rst, 0);
    endtask

    task automatic t_collision();
        rearm();
        wdt_timeout = 1'b1; reg_wr = 1'b1; reg_wdata = 8'h7F;
        @(negedge clk);
        wdt_timeout = 1'b0; reg_wr = 1'b0; reg_wdata = 8'h00;
        check(reg_rdata == 8'h77, "R11 event wins", reg_rdata, 8'h77);
        measure("R2 collide release");
    endtask

    task automatic t_prio();
        rearm();
        wr(8'h80);
        check(reg_rdata == 8'hFF, "R12 prio set", reg_rdata, 8'hFF);
        repeat (5) @(negedge clk);
        check(chip_rst == 1'b0, "R12 no reset", chip_rst, 0);
        wr(8'h00);
        check(reg_rdata == 8'h7F, "R12 prio clear", reg_rdata, 8'h7F);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R2 watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        por = 1'b0; ext_rst = 1'b0; pm_mode = 1'b0; wdt_timeout = 1'b0;
        bor_det = 1'b0; bor_en = 1'b1; sw_reset = 1'b0; stk_full = 1'b0;
        stk_under = 1'b0; reg_wr = 1'b0; reg_wdata = 8'h00;
        @(negedge clk);
        t_power_on();
        t_ext_run();
        t_ext_pm();
        t_wdt();
        t_bor();
        t_swr();
        t_stack();
        t_restart();
        t_sw_write();
        t_collision();
        t_prio();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule